// File: doc/BRIEF.md
# Latency-Priority Bus Arbiter

This block is the central arbiter for a shared bus with several masters. Each master has an active-low request line and an active-low grant line, plus a programmed maximum-latency value. A smaller latency value means that master needs the bus sooner, so it wins arbitration. Arbitration is hidden: the next owner can be chosen and granted while the current transaction is still running.

The arbiter watches two active-low bus-activity lines (a frame line and a ready line) to learn when the granted master has really begun. Until that moment, the grant may be taken back and moved to a more urgent requester. Once a master has begun, it cannot be pre-empted. If any other master asks for the bus, its grant is removed, and that removal tells it to finish up and hand the bus over.

Top module: `lat_arbiter`

## Requirements
- R1: Exactly one bit of `gnt_n` is low in every cycle. After reset, `gnt_n` is 4'b1110, meaning master 0 holds the parked grant.
- R2: While no master requests (`req_n` all ones), the grant does not change.
- R3: If the grant holder has not started and does not request, while some other master does, the grant moves in the next cycle to the requester that wins selection.
- R4: Selection takes the requester with the smallest latency value. Among equal values, the first requester in round-robin order wins. The order begins at the master after the last one that started a transaction. After reset, the order begins at master 0.
- R5: The holder counts as started in a cycle where `frame_n` is low and, in the previous cycle, both `frame_n` and `irdy_n` were high. The grant stays unchanged in that cycle.
- R6: Before the holder has started, while the bus is busy (`frame_n` or `irdy_n` low), a requester with a strictly smaller latency value takes the grant in the next cycle. A requester whose value is equal or larger does not.
- R7: While the bus is idle, a holder that has not started and still requests keeps its grant.
- R8: After the holder has started, if any other master requests, the grant leaves the holder in the next cycle. It goes to the winner chosen among the other requesters.
- R9: After the holder has started, if no other master requests, the holder keeps the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | N | Per-master bus request, active low |
| lat_cfg | input | N*LW | Maximum-latency value per master; master i in bits [i*LW +: LW], unsigned, smaller is more urgent |
| frame_n | input | 1 | Bus frame line, active low |
| irdy_n | input | 1 | Bus ready line, active low |
| gnt_n | output | N | Per-master grant, active low, one-cold |

## Verification
The assertions assume that masters drive `frame_n` and `irdy_n` as a real bus does. A start is recognised only on an idle-to-frame transition, and the assertions take that edge to belong to the holder of the grant. They also assume that `frame_n` and `irdy_n` are high during reset. The stimulus keeps the bus lines high through reset. After reset it toggles them at random, so some frame edges fall on holders that are not requesting. Because the arbiter is specified purely in terms of the ports, that case remains legal. Latency values are drawn from a small range so that ties happen often.

// File: rtl/lat_arbiter.sv
module lat_arbiter #(
  parameter int N  = 4,
  parameter int LW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_n,
  input  logic [N*LW-1:0] lat_cfg,
  input  logic            frame_n,
  input  logic            irdy_n,
  output logic [N-1:0]    gnt_n
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [LW-1:0] lat [N];
  logic [IW-1:0] cur_q, last_q, win, cand;
  logic [LW-1:0] best;
  logic          started_q, idle_q, found, busy, start_evt, move;

  for (genvar g = 0; g < N; g++) begin : g_lat
    assign lat[g] = lat_cfg[g*LW +: LW];
  end

  assign busy      = ~frame_n | ~irdy_n;
  assign start_evt = ~started_q & ~frame_n & idle_q;

  always_comb begin
    found = 1'b0;
    win   = cur_q;
    best  = '1;
    cand  = '0;
    for (int k = 1; k <= N; k++) begin
      cand = IW'((int'(last_q) + k) % N);
      if (!req_n[cand] && !(started_q && cand == cur_q) &&
          (!found || lat[cand] < best)) begin
        found = 1'b1;
        win   = cand;
        best  = lat[cand];
      end
    end
  end

  always_comb begin
    if (start_evt)      move = 1'b0;
    else if (started_q) move = found;
    else                move = found && (win != cur_q) &&
                               (req_n[cur_q] || (busy && lat[win] < lat[cur_q]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= '0;
      last_q    <= IW'(N - 1);
      started_q <= 1'b0;
      idle_q    <= 1'b1;
    end else begin
      idle_q <= ~busy;
      if (start_evt) begin
        started_q <= 1'b1;
        last_q    <= cur_q;
      end else if (move) begin
        cur_q     <= win;
        started_q <= 1'b0;
      end
    end
  end

  always_comb begin
    gnt_n        = '1;
    gnt_n[cur_q] = 1'b0;
  end
endmodule

// File: rtl/lat_arbiter_checks.sv
module lat_arbiter_checks #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_n,
  input logic         frame_n,
  input logic         irdy_n,
  input logic [N-1:0] gnt_n,
  input logic         started
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) == 1);  // R1

  AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (&req_n) |=> $stable(gnt_n));  // R2

  AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(gnt_n) || ((~gnt_n & ~$past(req_n)) != '0)));  // R3

  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_n && irdy_n) && !frame_n && !started) |=> (started && $stable(gnt_n)));  // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && irdy_n && !started && ((~gnt_n & ~req_n) != '0)) |=> $stable(gnt_n));  // R7

  AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (started && ((~req_n & gnt_n) != '0)) |=> (!started && !$stable(gnt_n)));  // R8
endmodule

bind lat_arbiter lat_arbiter_checks #(.N(N)) u_checks (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
  .irdy_n(irdy_n), .gnt_n(gnt_n), .started(started_q)
);

// File: tb/tb_lat_arbiter.sv
module tb_lat_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int LW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_n;
  logic [N*LW-1:0] lat_cfg;
  logic            frame_n, irdy_n;
  logic [N-1:0]    gnt_n;

  int nchk = 0, nfail = 0;
  int lt [N];
  int m_cur, m_last, m_started, m_idle;
  bit done = 0;

  lat_arbiter #(.N(N), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .lat_cfg(lat_cfg),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] cold(input int i);
    logic [N-1:0] v;
    v = '1;
    v[i] = 1'b0;
    return v;
  endfunction

  function automatic int pick(input logic [N-1:0] r, input int excl);
    int w;
    w = -1;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (m_last + k) % N;
      if (!r[c] && c != excl && (w < 0 || lt[c] < lt[w])) w = c;
    end
    return w;
  endfunction

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s gnt_n actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input bit f, input bit i);
    int w;
    bit busy;
    string tag;
    req_n   = r;
    frame_n = f;
    irdy_n  = i;
    for (int k = 0; k < N; k++) lat_cfg[k*LW +: LW] = LW'(lt[k]);
    busy = !f || !i;
    w = pick(r, m_started ? m_cur : -1);
    if (!m_started && !f && m_idle) begin
      tag = "R5"; m_started = 1; m_last = m_cur;
    end else if (m_started) begin
      if (w >= 0) begin tag = "R8"; m_cur = w; m_started = 0; end
      else tag = "R9";
    end else if (&r) tag = "R2";
    else if (r[m_cur]) begin tag = "R3"; m_cur = w; end
    else if (busy && lt[w] < lt[m_cur]) begin tag = "R6"; m_cur = w; end
    else tag = busy ? "R6" : "R7";
    m_idle = !busy;
    @(posedge clk);
    @(negedge clk);
    check(gnt_n, cold(m_cur), tag);
    nchk++;
    if ($countones(~gnt_n) != 1) begin
      nfail++;
      $display("FAIL R1 one-cold actual=%b expected=one low bit", gnt_n);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
    for (int k = 0; k < N; k++) lt[k] = 5;
    for (int k = 0; k < N; k++) lat_cfg[k*LW +: LW] = LW'(lt[k]);
    m_cur = 0; m_last = N - 1; m_started = 0; m_idle = 1;
    repeat (3) @(negedge clk);
    check(gnt_n, 4'b1110, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(gnt_n, 4'b1110, "R1 after reset");

    cyc(4'b0001, 1, 1);  check(gnt_n, 4'b1101, "R4 tie after reset");
    cyc(4'b1101, 1, 1);  check(gnt_n, 4'b1101, "R7 idle hold");
    cyc(4'b1101, 0, 1);  check(gnt_n, 4'b1101, "R5 start");
    cyc(4'b0000, 0, 0);  check(gnt_n, 4'b1011, "R4 R8 handoff round-robin");
    lt[3] = 1;
    cyc(4'b0011, 0, 0);  check(gnt_n, 4'b0111, "R6 preempt");
    lt[2] = 1;
    cyc(4'b0011, 0, 0);  check(gnt_n, 4'b0111, "R6 equal no preempt");
    cyc(4'b1111, 1, 1);  check(gnt_n, 4'b0111, "R2 park");
    cyc(4'b1111, 0, 0);  check(gnt_n, 4'b0111, "R2 park busy");
    cyc(4'b0111, 1, 1);
    cyc(4'b0111, 0, 1);
    cyc(4'b0111, 0, 0);  check(gnt_n, 4'b0111, "R9 sole owner");

    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] r;
      if (n % 50 == 0) for (int k = 0; k < N; k++) lt[k] = int'($urandom_range(0, 3));
      r = 4'($urandom);
      if ($urandom_range(0, 7) == 0) r = '1;
      cyc(r, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule